// File: doc/BRIEF.md
# LCD Init Script Interpreter

This block runs the short scripts a display panel needs at power-up, before sleep and on wake. A script sits in a small on-chip memory. A one-cycle start pulse, together with a base address and a format select, launches it. The engine then walks the script, fetching opcodes and their operands, and turns them into a stream of command and data words on a valid/ready output. It also inserts timed pauses and stops when it reaches the end marker.

It understands two script formats. The byte format is for panels with 8-bit command sets. Each memory location holds one byte in bits [7:0]. The word format is for panels with 16-bit register sets. Each location holds one 16-bit word: the action code sits in the low byte and a parameter in the high byte.

Pauses are counted on two tick-enable inputs, a microsecond tick and a coarse scheduler tick. The engine therefore needs no knowledge of the clock frequency.

The memory read port is combinational: `mem_rdata` must reflect `mem_addr` in the same cycle.

FSM states:
- IDLE: waiting for start.
- OP: fetch an opcode.
- BCMD, BLEN, BDAT, BSLP: the byte-format command byte, length, data bytes and sleep count.
- WCMD: the word-format command operand.
- WREG, WRC, WRD: the burst start register, the register command and the register data.
- EMIT: hold the output word until it is accepted.
- WAIT: count a delay.

Transitions:
- IDLE→OP on start.
- OP→(BCMD | BSLP | WCMD | WREG | WAIT | OP | IDLE) by opcode.
- BCMD→EMIT→BLEN.
- BLEN→BDAT, or BLEN→OP when the length is zero.
- BDAT→EMIT→(BDAT | OP).
- BSLP→(WAIT | OP).
- WCMD→EMIT→OP.
- WREG→(WRC | OP).
- WRC→EMIT→WRD.
- WRD→EMIT→(WRC | OP).
- WAIT→OP on expiry.

Top module: `lcd_script_engine`

## Requirements
- R1: After reset, `busy` and `out_valid` are low.
- R2: When idle, a `start` pulse begins execution at `base_addr` in the format given by `fmt_word` (0 = byte, 1 = word). `busy` is high from the next cycle until the end marker has been read.
- R3: Byte format, opcode 0x01 (command): the next byte is emitted as a command word, zero-extended. The byte after it is a length N, and the N bytes that follow are emitted in order as data words. N = 0 emits the command alone.
- R4: Byte format, opcode 0x02 (sleep): the next byte N is a count of coarse ticks. No further output appears before N `coarse_tick` pulses have been seen. N = 0 does not wait.
- R5: Opcode 0x00 ends the script, and so does any code not defined for the current format. `busy` falls and nothing more is emitted. In byte format, 0x03 and 0x04 are undefined.
- R6: Word format, action 0x01 (command): the following word is emitted unchanged as a command word.
- R7: Word format, action 0x03 (burst): the following word is a start register R and the parameter P (bits [15:8]) is a count. For each of the next P words in turn, the engine emits command R+i and then that word as data. P = 0 emits nothing.
- R8: Word format, action 0x04 (short delay): the engine waits P×64 `us_tick` pulses before fetching the next opcode.
- R9: Word format, action 0x02 (sleep): the engine waits P `coarse_tick` pulses. P = 0 does not wait.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_word` and `out_is_cmd` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, honoured only when idle |
| base_addr | input | AW | Script start address |
| fmt_word | input | 1 | Script format: 0 byte, 1 word |
| us_tick | input | 1 | Microsecond tick enable |
| coarse_tick | input | 1 | Coarse scheduler tick enable |
| mem_addr | output | AW | Script memory read address |
| mem_rdata | input | 16 | Script memory read data (combinational) |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Output word accepted |
| out_is_cmd | output | 1 | 1 = command word, 0 = data word |
| out_word | output | 16 | Command or data word |
| busy | output | 1 | Script running |

## Verification
Output words leave from the EMIT state, one cycle after the operand fetch that produced them. Their exact cycle also depends on `out_ready`, so the scoreboard compares words only at accepted handshakes, sampled on the falling edge, and never at fixed offsets. A delay ends two cycles after its last tick, with one cycle to fetch the next opcode and one for the operand, and the word follows in EMIT. Delay checks therefore assert silence for long stretches before the final tick and expect a word within a few cycles after it. The short delay of P = 2 is checked as a window of 128 to 140 cycles between start and first output, with `us_tick` held high.

// File: rtl/lcd_script_pkg.sv
package lcd_script_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_OP, S_BCMD, S_BLEN, S_BDAT, S_BSLP,
        S_WCMD, S_WREG, S_WRC, S_WRD, S_EMIT, S_WAIT
    } eng_state_t;

    localparam logic [7:0] OP_END   = 8'h00;
    localparam logic [7:0] OP_CMD   = 8'h01;
    localparam logic [7:0] OP_SLEEP = 8'h02;
    localparam logic [7:0] OP_BURST = 8'h03;
    localparam logic [7:0] OP_DELAY = 8'h04;
endpackage

// File: rtl/lcd_script_delay.sv
module lcd_script_delay #(
    parameter int CW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          use_us,
    input  logic          us_tick,
    input  logic          coarse_tick,
    output logic          expired
);
    logic [CW-1:0] cnt;
    logic          sel_us;
    logic          tick;

    assign tick    = sel_us ? us_tick : coarse_tick;
    assign expired = (cnt == CW'(1)) && tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            sel_us <= 1'b0;
        end else if (load) begin
            cnt    <= load_val;
            sel_us <= use_us;
        end else if (cnt != '0 && tick) begin
            cnt <= cnt - CW'(1);
        end
    end

    // R8 / R9: without a load the remaining count never grows
    assert_count_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> cnt <= $past(cnt));
endmodule

// File: rtl/lcd_script_engine.sv
module lcd_script_engine
    import lcd_script_pkg::*;
#(
    parameter int AW         = 8,
    parameter int TICK_SHIFT = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] base_addr,
    input  logic          fmt_word,
    input  logic          us_tick,
    input  logic          coarse_tick,
    output logic [AW-1:0] mem_addr,
    input  logic [15:0]   mem_rdata,
    output logic          out_valid,
    input  logic          out_ready,
    output logic          out_is_cmd,
    output logic [15:0]   out_word,
    output logic          busy
);
    localparam int CW = 8 + TICK_SHIFT;

    eng_state_t st, st_n, ret, ret_n;
    logic [AW-1:0] ptr, ptr_n;
    logic          fmt, fmt_n;
    logic [7:0]    cnt, cnt_n;
    logic [15:0]   rnum, rnum_n;
    logic [15:0]   ow_n;
    logic          oc_n;
    logic          dl_load, dl_us, dl_exp;
    logic [CW-1:0] dl_val;
    logic [7:0]    op, prm, lo;

    assign op        = mem_rdata[7:0];
    assign lo        = mem_rdata[7:0];
    assign prm       = mem_rdata[15:8];
    assign mem_addr  = ptr;
    assign busy      = (st != S_IDLE);
    assign out_valid = (st == S_EMIT);

    lcd_script_delay #(.CW(CW)) u_delay (
        .clk(clk), .rst_n(rst_n), .load(dl_load), .load_val(dl_val),
        .use_us(dl_us), .us_tick(us_tick), .coarse_tick(coarse_tick),
        .expired(dl_exp)
    );

    always_comb begin
        st_n    = st;
        ret_n   = ret;
        ptr_n   = ptr;
        fmt_n   = fmt;
        cnt_n   = cnt;
        rnum_n  = rnum;
        ow_n    = out_word;
        oc_n    = out_is_cmd;
        dl_load = 1'b0;
        dl_us   = 1'b0;
        dl_val  = '0;
        unique case (st)
            S_IDLE: if (start) begin
                ptr_n = base_addr;
                fmt_n = fmt_word;
                st_n  = S_OP;
            end
            S_OP: begin
                ptr_n = ptr + AW'(1);
                st_n  = S_IDLE;
                if (!fmt) begin
                    if (op == OP_CMD)        st_n = S_BCMD;
                    else if (op == OP_SLEEP) st_n = S_BSLP;
                end else begin
                    if (op == OP_CMD) st_n = S_WCMD;
                    else if (op == OP_BURST) begin
                        cnt_n = prm;
                        st_n  = S_WREG;
                    end else if (op == OP_SLEEP || op == OP_DELAY) begin
                        dl_load = 1'b1;
                        dl_us   = (op == OP_DELAY);
                        dl_val  = dl_us ? {prm, TICK_SHIFT'(0)} : CW'(prm);
                        st_n    = (prm == 8'd0) ? S_OP : S_WAIT;
                    end
                end
            end
            S_BCMD: begin
                ptr_n = ptr + AW'(1);
                ow_n  = {8'h00, lo};
                oc_n  = 1'b1;
                ret_n = S_BLEN;
                st_n  = S_EMIT;
            end
            S_BLEN: begin
                ptr_n = ptr + AW'(1);
                cnt_n = lo;
                st_n  = (lo == 8'd0) ? S_OP : S_BDAT;
            end
            S_BDAT: begin
                ptr_n = ptr + AW'(1);
                cnt_n = cnt - 8'd1;
                ow_n  = {8'h00, lo};
                oc_n  = 1'b0;
                ret_n = (cnt == 8'd1) ? S_OP : S_BDAT;
                st_n  = S_EMIT;
            end
            S_BSLP: begin
                ptr_n   = ptr + AW'(1);
                dl_load = 1'b1;
                dl_val  = CW'(lo);
                st_n    = (lo == 8'd0) ? S_OP : S_WAIT;
            end
            S_WCMD: begin
                ptr_n = ptr + AW'(1);
                ow_n  = mem_rdata;
                oc_n  = 1'b1;
                ret_n = S_OP;
                st_n  = S_EMIT;
            end
            S_WREG: begin
                ptr_n  = ptr + AW'(1);
                rnum_n = mem_rdata;
                st_n   = (cnt == 8'd0) ? S_OP : S_WRC;
            end
            S_WRC: begin
                ow_n  = rnum;
                oc_n  = 1'b1;
                ret_n = S_WRD;
                st_n  = S_EMIT;
            end
            S_WRD: begin
                ptr_n  = ptr + AW'(1);
                rnum_n = rnum + 16'd1;
                cnt_n  = cnt - 8'd1;
                ow_n   = mem_rdata;
                oc_n   = 1'b0;
                ret_n  = (cnt == 8'd1) ? S_OP : S_WRC;
                st_n   = S_EMIT;
            end
            S_EMIT: if (out_ready) st_n = ret;
            S_WAIT: if (dl_exp) st_n = S_OP;
            default: st_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ret        <= S_OP;
            ptr        <= '0;
            fmt        <= 1'b0;
            cnt        <= '0;
            rnum       <= '0;
            out_word   <= '0;
            out_is_cmd <= 1'b0;
        end else begin
            ret        <= ret_n;
            ptr        <= ptr_n;
            fmt        <= fmt_n;
            cnt        <= cnt_n;
            rnum       <= rnum_n;
            out_word   <= ow_n;
            out_is_cmd <= oc_n;
        end
    end

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_is_cmd));
    assert_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !out_valid);
    assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy);
    assert_wait_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WAIT) && !dl_exp |=> !out_valid);
endmodule

// File: tb/lcd_script_engine_tb.sv
module lcd_script_engine_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  base_addr = '0;
    logic        fmt_word = 1'b0;
    logic        us_tick = 1'b0;
    logic        coarse_tick = 1'b0;
    logic [7:0]  mem_addr;
    logic [15:0] mem_rdata;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic        out_is_cmd;
    logic [15:0] out_word;
    logic        busy;

    logic [15:0] rom [256];
    int          wp;
    int          total = 0;
    int          bad = 0;
    int          emitted = 0;
    int          cyc = 0;
    int          last_cyc = 0;
    int          t0;
    logic        stall = 1'b0;
    logic [7:0]  rpat = 8'b1011_0010;
    logic [16:0] expq [$];
    string       tagq [$];

    assign mem_rdata = rom[mem_addr];

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_script_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .fmt_word(fmt_word), .us_tick(us_tick), .coarse_tick(coarse_tick),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .out_valid(out_valid),
        .out_ready(out_ready), .out_is_cmd(out_is_cmd), .out_word(out_word),
        .busy(busy)
    );

    always @(posedge clk) begin
        #1;
        rpat      = {rpat[6:0], rpat[7]};
        out_ready = stall ? rpat[0] : 1'b1;
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n && out_valid && out_ready) begin
            emitted++;
            last_cyc = cyc;
            if (expq.size() == 0) begin
                chk(1'b0, "unexpected output", {out_is_cmd, out_word}, 0);
            end else begin
                logic [16:0] e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                chk({out_is_cmd, out_word} == e, t, {out_is_cmd, out_word}, e);
            end
        end
    end

    task automatic expect_item(input logic c, input logic [15:0] w, input string t);
        expq.push_back({c, w});
        tagq.push_back(t);
    endtask

    task automatic wr(input logic [15:0] v);
        rom[wp] = v;
        wp++;
    endtask

    task automatic launch(input logic [7:0] b, input logic f);
        @(posedge clk); #1;
        base_addr = b; fmt_word = f; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic wait_idle(input string t);
        int n = 0;
        while (busy && n < 2000) begin @(posedge clk); n++; end
        @(negedge clk);
        chk(!busy, t, busy, 0);
        chk(expq.size() == 0, t, expq.size(), 0);
    endtask

    task automatic pulse_coarse();
        @(posedge clk); #1 coarse_tick = 1'b1;
        @(posedge clk); #1 coarse_tick = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int e0;
        for (int i = 0; i < 256; i++) rom[i] = 16'h0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy && !out_valid, "R1 reset state", {busy, out_valid}, 0);
        rst_n = 1'b1;

        // R3: byte command with four data bytes, then a zero-length command
        wp = 16;
        wr(16'h01); wr(16'h2a); wr(16'h04); wr(16'h00); wr(16'h01); wr(16'h00); wr(16'hef);
        wr(16'h01); wr(16'h2c); wr(16'h00); wr(16'h00);
        expect_item(1, 16'h002a, "R3 cmd byte");
        expect_item(0, 16'h0000, "R3 data0");
        expect_item(0, 16'h0001, "R3 data1");
        expect_item(0, 16'h0000, "R3 data2");
        expect_item(0, 16'h00ef, "R3 data3");
        expect_item(1, 16'h002c, "R3 zero length cmd");
        stall = 1'b1;
        launch(8'd16, 1'b0);
        @(negedge clk);
        chk(busy, "R2 busy after start", busy, 1);
        wait_idle("R2 byte script end");
        stall = 1'b0;

        // R4: byte sleep of 3 coarse ticks
        wp = 48;
        wr(16'h02); wr(16'h03); wr(16'h01); wr(16'h11); wr(16'h01); wr(16'h55); wr(16'h00);
        expect_item(1, 16'h0011, "R4 cmd after sleep");
        expect_item(0, 16'h0055, "R4 data after sleep");
        e0 = emitted;
        launch(8'd48, 1'b0);
        repeat (30) @(posedge clk);
        @(negedge clk);
        chk(emitted == e0 && busy, "R4 silent before ticks", emitted - e0, 0);
        pulse_coarse(); pulse_coarse();
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk(emitted == e0, "R4 silent after 2 of 3 ticks", emitted - e0, 0);
        pulse_coarse();
        repeat (10) @(posedge clk);
        wait_idle("R4 sleep script end");

        // R5: undefined byte opcode stops the script
        wp = 64;
        wr(16'h04); wr(16'h01); wr(16'h33); wr(16'h00); wr(16'h00);
        e0 = emitted;
        launch(8'd64, 1'b0);
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk(emitted == e0, "R5 undefined opcode emits nothing", emitted - e0, 0);
        chk(!busy, "R5 undefined opcode ends", busy, 0);

        // R6, R7, R9: word command, burst of three, zero sleep, end
        wp = 96;
        wr(16'h0001); wr(16'h1234);
        wr(16'h0303); wr(16'h0210); wr(16'haaaa); wr(16'hbbbb); wr(16'hcccc);
        wr(16'h0002); wr(16'h0000);
        expect_item(1, 16'h1234, "R6 word cmd");
        expect_item(1, 16'h0210, "R7 reg0");
        expect_item(0, 16'haaaa, "R7 data0");
        expect_item(1, 16'h0211, "R7 reg1");
        expect_item(0, 16'hbbbb, "R7 data1");
        expect_item(1, 16'h0212, "R7 reg2");
        expect_item(0, 16'hcccc, "R7 data2");
        stall = 1'b1;
        launch(8'd96, 1'b1);
        wait_idle("R9 zero sleep then end");
        stall = 1'b0;

        // R7: burst with count zero emits nothing
        wp = 128;
        wr(16'h0003); wr(16'h0300); wr(16'h0001); wr(16'h0077); wr(16'h0000);
        expect_item(1, 16'h0077, "R7 empty burst then cmd");
        launch(8'd128, 1'b1);
        wait_idle("R7 empty burst end");

        // R8: short delay of 2 -> 128 us ticks
        wp = 160;
        wr(16'h0204); wr(16'h0001); wr(16'h00ee); wr(16'h0000);
        expect_item(1, 16'h00ee, "R8 cmd after delay");
        us_tick = 1'b1;
        t0 = cyc;
        launch(8'd160, 1'b1);
        wait_idle("R8 delay script end");
        chk(last_cyc - t0 >= 128 && last_cyc - t0 <= 140, "R8 delay window", last_cyc - t0, 128);
        us_tick = 1'b0;

        // R9: word sleep of 2 coarse ticks
        wp = 192;
        wr(16'h0202); wr(16'h0001); wr(16'h0099); wr(16'h0000);
        expect_item(1, 16'h0099, "R9 cmd after sleep");
        e0 = emitted;
        launch(8'd192, 1'b1);
        repeat (20) @(posedge clk);
        pulse_coarse();
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk(emitted == e0 && busy, "R9 silent after 1 of 2 ticks", emitted - e0, 0);
        pulse_coarse();
        wait_idle("R9 sleep script end");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule